// File: doc/BRIEF.md
# Interrupt Pending Aggregator

This block gathers interrupt requests from a set of GPIO banks and from a set of other peripheral sources into one pending-status word. It keeps a mask word that holds a global enable and an enable bit for every non-GPIO source. From these it drives one interrupt line to the host, and the host takes that line as a rising edge. The GPIO banks and the peripherals sit outside the block. Each of them shows up here only as a request wire.

The host uses a two-entry register port. Entry 0 is the status word. Entry 1 is the mask word. Bank summaries take the low status bits in bank order, and the peripheral sources take the bits above them. The host counts the block as idle once every status bit reads zero. Each write to the status entry acknowledges the interrupt and pulls the host line low for one cycle. If unmasked work is still pending, the line rises again, so the edge-triggered host never misses a source that stayed pending.

Top module: `irq_aggr_top`

## Requirements
- R1: After a synchronous reset, every status bit, every mask bit and `host_irq` are zero, and both register entries read as zero.
- R2: Status bits 0 to 3 show `bank_irq_in[3:0]` (bank 0 at bit 0) one cycle after they are sampled. Writing 1s to these bits has no effect.
- R3: Status bit 4+j becomes 1 in the cycle after `src_irq_in[j]` goes from 0 to 1.
- R4: Status bit 4+j reads 0 in the cycle after any cycle in which `src_irq_in[j]` is 0.
- R5: Writing a 1 to status bit 4+j through entry 0 clears that bit. The bit then stays clear while the source remains high, until the source rises again. A rise in the same cycle as the write sets the bit.
- R6: Mask entry 1 holds the global enable at bit 0 and the enable for source j at bit 4+j. All other bits read 0. A 1 in any of these bits means enabled.
- R7: While the global enable is 0, `host_irq` stays low.
- R8: With the global enable at 1, any set bank bit counts as pending. A source bit counts as pending only when its own enable bit is 1.
- R9: `host_irq` is high in the cycle after the registered status and mask show unmasked pending work. It is low in the cycle after they show none.
- R10: A write to entry 0 forces `host_irq` low for the next cycle. If unmasked work is still pending, the line rises again one cycle later.
- R11: `reg_rdata` is combinational. Entry 0 returns the 10 status bits in bits 9:0, and bits 15:10 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_irq_in | input | 4 | Summary request from each GPIO bank |
| src_irq_in | input | 6 | Request from each non-GPIO source |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected entry |
| host_irq | output | 1 | Interrupt line to the host, rising-edge meaning |

## Verification
Several behaviours are checked by assertions on every cycle:
- A source bit sets after its rise.
- A source bit reads zero after its source is low.
- A write-1 clears a source bit that is held high.
- The host line is low whenever the global enable was off.
- An acknowledge write makes the host line drop.

Other behaviours only the bench scenarios can show:
- The bank bits follow their inputs, and writes to them are ignored.
- The exact enable selection across all 64 source-enable patterns.
- The line rising again after an acknowledge while work is still pending.
- The readback layout of both entries.

The bench checks these against a model built from the requirements. It runs directed sweeps followed by a long pseudo-random sequence.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    localparam int NUM_BANKS = 4;
    localparam int NUM_SRCS  = 6;
    localparam int REG_W     = 16;
    localparam int STAT_W    = NUM_BANKS + NUM_SRCS;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    // Bank summaries occupy the low bits, sources sit above them.
    typedef struct packed {
        logic [NUM_SRCS-1:0]  src;
        logic [NUM_BANKS-1:0] bank;
    } status_t;

    // Source enables line up with their status bits; bit 0 is the global enable.
    typedef struct packed {
        logic [NUM_SRCS-1:0]  src_en;
        logic [NUM_BANKS-2:0] rsvd;
        logic                 global_en;
    } mask_t;

    function automatic logic [REG_W-1:0] status_to_reg(status_t s);
        return REG_W'(s);
    endfunction

    function automatic logic [REG_W-1:0] mask_to_reg(mask_t m);
        return REG_W'(m);
    endfunction

    function automatic mask_t reg_to_mask(logic [REG_W-1:0] d);
        mask_t m;
        m.global_en = d[0];
        m.rsvd      = '0;
        m.src_en    = d[NUM_BANKS +: NUM_SRCS];
        return m;
    endfunction

endpackage

// File: rtl/irq_aggr_status.sv
module irq_aggr_status
    import irq_aggr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] bank_in,
    input  logic [NUM_SRCS-1:0]  src_in,
    input  logic [NUM_SRCS-1:0]  clr_in,
    output status_t              stat_q
);

    logic [NUM_BANKS-1:0] bank_q;
    logic [NUM_SRCS-1:0]  src_q;
    logic [NUM_SRCS-1:0]  src_prev;
    logic [NUM_SRCS-1:0]  src_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q   <= '0;
            src_q    <= '0;
            src_prev <= '0;
        end else begin
            bank_q   <= bank_in;
            src_q    <= src_next;
            src_prev <= src_in;
        end
    end

    for (genvar j = 0; j < NUM_SRCS; j++) begin : g_src
        logic rise;
        assign rise = src_in[j] & ~src_prev[j];

        // A rise wins over a clear in the same cycle; a low source always clears.
        always_comb src_next[j] = src_in[j] & ((src_q[j] & ~clr_in[j]) | rise);

        assert_set_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(src_in[j]) |=> src_q[j]);

        assert_clear_on_low_R4: assert property (@(posedge clk) disable iff (rst)
            !$past(src_in[j]) |-> !src_q[j]);

        assert_w1c_holds_R5: assert property (@(posedge clk) disable iff (rst)
            (clr_in[j] && $past(src_in[j])) |=> !src_q[j]);
    end

    assign stat_q.bank = bank_q;
    assign stat_q.src  = src_q;

endmodule

// File: rtl/irq_aggr_mask.sv
module irq_aggr_mask
    import irq_aggr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output mask_t            mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= reg_to_mask(wdata);
        end
    end

endmodule

// File: rtl/irq_aggr_host.sv
module irq_aggr_host
    import irq_aggr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  status_t stat,
    input  mask_t   mask,
    input  logic    ack,
    output logic    host_irq
);

    logic bank_any;
    logic src_any;
    logic pending;
    logic line_q;

    assign bank_any = |stat.bank;
    assign src_any  = |(stat.src & mask.src_en);
    assign pending  = mask.global_en & (bank_any | src_any);

    // An acknowledge forces a low cycle so a still-pending request rises anew.
    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
        end else begin
            line_q <= pending & ~ack;
        end
    end

    assign host_irq = line_q;

    assert_global_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !mask.global_en |=> !host_irq);

    assert_ack_drops_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !host_irq);

endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
    import irq_aggr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] bank_irq_in,
    input  logic [NUM_SRCS-1:0]  src_irq_in,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 host_irq
);

    reg_sel_e            sel;
    logic                wr_status;
    logic                wr_mask;
    logic [NUM_SRCS-1:0] clr_vec;
    status_t             stat;
    mask_t               mask;

    assign sel       = reg_sel_e'(reg_sel);
    assign wr_status = reg_wr && (sel == SEL_STATUS);
    assign wr_mask   = reg_wr && (sel == SEL_MASK);
    assign clr_vec   = wr_status ? reg_wdata[NUM_BANKS +: NUM_SRCS] : '0;

    irq_aggr_status u_status (
        .clk     (clk),
        .rst     (rst),
        .bank_in (bank_irq_in),
        .src_in  (src_irq_in),
        .clr_in  (clr_vec),
        .stat_q  (stat)
    );

    irq_aggr_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_mask),
        .wdata  (reg_wdata),
        .mask_q (mask)
    );

    irq_aggr_host u_host (
        .clk      (clk),
        .rst      (rst),
        .stat     (stat),
        .mask     (mask),
        .ack      (wr_status),
        .host_irq (host_irq)
    );

    always_comb begin
        case (sel)
            SEL_STATUS: reg_rdata = status_to_reg(stat);
            default:    reg_rdata = mask_to_reg(mask);
        endcase
    end

endmodule

// File: tb/sim_irq_aggr_top.sv
`timescale 1ns/1ps
module sim_irq_aggr_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bank = '0;
    logic [5:0]  src = '0;
    logic        wr = 1'b0;
    logic        sel = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        host;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_aggr_top u0 (
        .clk         (clk),
        .rst         (rst),
        .bank_irq_in (bank),
        .src_irq_in  (src),
        .reg_wr      (wr),
        .reg_sel     (sel),
        .reg_wdata   (wdata),
        .reg_rdata   (rdata),
        .host_irq    (host)
    );

    // Requirement model, advanced on the same edge as the design.
    logic [3:0] m_bank = '0;
    logic [5:0] m_src = '0, m_prev = '0, m_en = '0;
    logic       m_glob = 1'b0, m_host = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_bank <= '0; m_src <= '0; m_prev <= '0;
            m_en <= '0; m_glob <= 1'b0; m_host <= 1'b0;
        end else begin
            logic [5:0] clr;
            logic       pend;
            clr  = (wr && !sel) ? wdata[9:4] : 6'h0;
            pend = m_glob && ((m_bank != 0) || ((m_src & m_en) != 0));
            m_bank <= bank;
            m_prev <= src;
            m_src  <= src & ((m_src & ~clr) | (src & ~m_prev));
            if (wr && sel) begin
                m_glob <= wdata[0];
                m_en   <= wdata[9:4];
            end
            m_host <= pend && !(wr && !sel);
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [15:0] exp;
        chk(m_glob ? "R8 R9 R10 host_irq" : "R7 host_irq", {15'h0, host}, {15'h0, m_host});
        if (!sel) begin
            exp = {6'h0, m_src, m_bank};
            chk("R2 bank bits", {12'h0, rdata[3:0]}, {12'h0, exp[3:0]});
            chk("R3 R4 R5 source bits", rdata, exp);
            chk("R11 upper zero", {10'h0, rdata[15:10]}, 16'h0);
        end else begin
            exp = {6'h0, m_en, 3'h0, m_glob};
            chk("R6 mask readback", rdata, exp);
        end
    endtask

    // One cycle: check settled outputs, then drive the next inputs.
    task automatic cyc(input logic [3:0] b, input logic [5:0] s, input logic w,
                       input logic sl, input logic [15:0] wd);
        @(negedge clk);
        compare();
        bank = b; src = s; wr = w; sel = sl; wdata = wd;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: reset state on both entries
        sel = 1'b0; #1 chk("R1 status reset", rdata, 16'h0);
        sel = 1'b1; #1 chk("R1 mask reset", rdata, 16'h0);
        chk("R1 host reset", {15'h0, host}, 16'h0);
        sel = 1'b0;
        rst = 1'b0;

        // R2 R7: bank sweep with global enable off, then try writing 1s to bank bits
        for (int b = 0; b < 16; b++) cyc(b[3:0], 6'h0, 1'b0, 1'b0, 16'h0);
        cyc(4'hF, 6'h0, 1'b1, 1'b0, 16'h000F);
        cyc(4'hF, 6'h0, 1'b0, 1'b0, 16'h0);
        cyc(4'hF, 6'h0, 1'b0, 1'b0, 16'h0);

        // R6: mask layout, reserved bits written as 1
        cyc(4'h0, 6'h0, 1'b1, 1'b1, 16'hFFFF);
        cyc(4'h0, 6'h0, 1'b0, 1'b1, 16'h0);
        cyc(4'h0, 6'h0, 1'b1, 1'b1, 16'h0001);
        cyc(4'h0, 6'h0, 1'b0, 1'b0, 16'h0);

        // R8 R9: bank bits alone with global on
        for (int b = 0; b < 16; b++) begin
            cyc(b[3:0], 6'h0, 1'b0, 1'b0, 16'h0);
            cyc(b[3:0], 6'h0, 1'b0, 1'b0, 16'h0);
        end
        cyc(4'h0, 6'h0, 1'b0, 1'b0, 16'h0);

        // R3 R4 R8: each enable pattern against each single source
        for (int e = 0; e < 64; e++) begin
            cyc(4'h0, 6'h0, 1'b1, 1'b1, {6'h0, e[5:0], 4'h1});
            for (int j = 0; j < 6; j++) begin
                cyc(4'h0, 6'(1 << j), 1'b0, 1'b0, 16'h0);
                cyc(4'h0, 6'(1 << j), 1'b0, 1'b0, 16'h0);
                cyc(4'h0, 6'(1 << j), 1'b0, 1'b0, 16'h0);
                cyc(4'h0, 6'h0, 1'b0, 1'b0, 16'h0);
                cyc(4'h0, 6'h0, 1'b0, 1'b0, 16'h0);
            end
        end

        // R5 R10: held source, write-1 clear, then re-rise; ack while bank pending
        cyc(4'h0, 6'h0, 1'b1, 1'b1, 16'h03F1);
        cyc(4'h0, 6'h3F, 1'b0, 1'b0, 16'h0);
        cyc(4'h0, 6'h3F, 1'b0, 1'b0, 16'h0);
        cyc(4'h0, 6'h3F, 1'b1, 1'b0, 16'h0150);
        cyc(4'h0, 6'h3F, 1'b0, 1'b0, 16'h0);
        cyc(4'h0, 6'h3F, 1'b1, 1'b0, 16'h03F0);
        cyc(4'h0, 6'h3F, 1'b0, 1'b0, 16'h0);
        cyc(4'h0, 6'h3E, 1'b0, 1'b0, 16'h0);
        cyc(4'h0, 6'h3F, 1'b1, 1'b0, 16'h0010);
        cyc(4'h0, 6'h3F, 1'b0, 1'b0, 16'h0);
        cyc(4'h2, 6'h0, 1'b0, 1'b0, 16'h0);
        cyc(4'h2, 6'h0, 1'b0, 1'b0, 16'h0);
        cyc(4'h2, 6'h0, 1'b1, 1'b0, 16'h0);
        cyc(4'h2, 6'h0, 1'b0, 1'b0, 16'h0);
        cyc(4'h2, 6'h0, 1'b0, 1'b0, 16'h0);
        cyc(4'h2, 6'h0, 1'b0, 1'b0, 16'h0);

        // Pseudo-random sweep over all inputs
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[3:0], lfsr[9:4], (lfsr[12:10] == 3'b0), lfsr[13], lfsr[31:16]);
        end
        cyc(4'h0, 6'h0, 1'b0, 1'b0, 16'h0);
        @(negedge clk);
        compare();
        finish_run();
    end

endmodule